// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, given as a segment number and an offset, into a physical address. It keeps a small on-chip table of segment descriptors and a register that holds how many segments are in use. Each descriptor has a base, a limit, a valid flag and three permission flags: read, write and execute. A request is checked in a fixed order. First the segment number is compared with the segment count. Then the descriptor's valid flag and its permission for the access type are examined. Last, the offset is compared with the limit. The response reports the first check that fails as a fault code, or reports the base plus the offset when every check passes.

Configuration comes in through a simple write strobe. A strobe either loads one descriptor, chosen by index, or loads the segment count. Translation is registered, so a request presented in one cycle has its response in the next cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, no response is valid, the fault and address outputs are zero, the segment count is 0 and every descriptor is invalid. A request made before any configuration therefore returns fault code 1.
- R2: A request with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle. A cycle without a request gives `rsp_valid` low in the next cycle, with the fault and address outputs at zero.
- R3: A segment number that is greater than or equal to the segment count returns fault code 1.
- R4: A segment whose descriptor has its valid flag at 0 returns fault code 2.
- R5: The access type is encoded as 0 read, 1 write, 2 execute and 3 reserved. Read needs permission bit 0, write needs bit 1 and execute needs bit 2. The reserved type is never permitted. A failed permission check returns fault code 3.
- R6: An offset greater than or equal to the descriptor's limit returns fault code 4.
- R7: When every check passes, the fault code is 0 and the physical address is base plus offset, taken modulo 2^PA_W.
- R8: Whenever the fault code is nonzero, the physical address output is zero.
- R9: A strobe with `cfg_sel` = 0 loads the descriptor at `cfg_idx`. A strobe with `cfg_sel` = 1 loads the segment count. The new value is used only from the cycle after the strobe, so a request in the same cycle as the strobe sees the old value.
- R10: When several checks would fail, the lowest fault code is reported. The order is 1, then 2, then 3, then 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 loads a descriptor, 1 loads the segment count |
| cfg_idx | input | SEG_W | Index of the descriptor to load |
| cfg_base | input | PA_W | Descriptor base |
| cfg_limit | input | OFF_W | Descriptor limit (segment length) |
| cfg_valid | input | 1 | Descriptor valid flag |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len | input | SEG_W+1 | Segment count value |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 3 | Fault code (0 none, 1 range, 2 invalid, 3 permission, 4 limit) |

## Verification
The assertions check on every cycle that a response follows each request and only a request. They also check that a faulting response always carries a zero address, that fault codes never exceed 4, and that a segment number at or above the count always gives code 1. The directed scenarios are the only evidence for everything else: the exact sum with wraparound, each permission encoding, the strict limit boundary, the priority among faults that fail together, and the rule that a same-cycle write is not yet visible to a request.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [OFF_W-1:0]  cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic [SEG_W:0]    cfg_len,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault
);

  localparam int NSEG = 1 << SEG_W;

  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_RANGE = 3'd1;
  localparam logic [2:0] F_INVAL = 3'd2;
  localparam logic [2:0] F_PERM  = 3'd3;
  localparam logic [2:0] F_LIMIT = 3'd4;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  valid_q;
  logic [2:0]       perm_q  [NSEG];
  logic [SEG_W:0]   len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      len_q   <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel) begin
        len_q <= cfg_len;
      end else begin
        base_q[cfg_idx]  <= cfg_base;
        limit_q[cfg_idx] <= cfg_limit;
        valid_q[cfg_idx] <= cfg_valid;
        perm_q[cfg_idx]  <= cfg_perm;
      end
    end
  end

  wire [2:0] ent_perm = perm_q[req_seg];
  wire seg_ok   = {1'b0, req_seg} < len_q;
  wire perm_ok  = (req_acc != 2'd3) && ent_perm[req_acc];
  wire off_ok   = req_off < limit_q[req_seg];

  logic [2:0] fault_n;
  always_comb begin
    if (!seg_ok)                fault_n = F_RANGE;
    else if (!valid_q[req_seg]) fault_n = F_INVAL;
    else if (!perm_ok)          fault_n = F_PERM;
    else if (!off_ok)           fault_n = F_LIMIT;
    else                        fault_n = F_NONE;
  end

  wire [PA_W-1:0] sum_n = base_q[req_seg] + PA_W'(req_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_n : F_NONE;
      rsp_paddr <= (req_valid && fault_n == F_NONE) ? sum_n : '0;
    end
  end

  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_paddr == '0));

  assert_range_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_fault == 3'd1));

  assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 3'd0) |-> (rsp_paddr == '0));

  assert_fault_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault <= 3'd4);

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_valid = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [OFF_W-1:0] cfg_limit = '0;
  logic [2:0] cfg_perm = '0;
  logic [SEG_W:0] cfg_len = '0;
  logic req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0] req_acc = '0;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic [2:0] rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
    .cfg_len(cfg_len), .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  task automatic check(string req, logic v, logic [2:0] f, logic [PA_W-1:0] pa,
                       logic ev, logic [2:0] ef, logic [PA_W-1:0] epa);
    n_chk++;
    if (v !== ev || f !== ef || pa !== epa) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b fault=%0d paddr=%h, expected valid=%0b fault=%0d paddr=%h",
               req, v, f, pa, ev, ef, epa);
    end
  endtask

  task automatic put_entry(int idx, logic [PA_W-1:0] b, logic [OFF_W-1:0] l, logic vld, logic [2:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = SEG_W'(idx);
    cfg_base = b; cfg_limit = l; cfg_valid = vld; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_len(int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = (SEG_W+1)'(n);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(string req, int seg, int off, int acc, logic [2:0] ef, logic [PA_W-1:0] epa);
    @(negedge clk);
    req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, rsp_valid, rsp_fault, rsp_paddr, 1'b1, ef, epa);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 3'd0, '0);
    rst_n = 1'b1;
    xlate("R1 unconfigured request", 0, 0, 0, 3'd1, '0);
  endtask

  task automatic t_setup();
    put_entry(0, 16'h1000, 12'h100, 1'b1, 3'b011);
    put_entry(1, 16'h2000, 12'h040, 1'b1, 3'b100);
    put_entry(2, 16'hFF80, 12'h200, 1'b1, 3'b111);
    put_entry(3, 16'h3000, 12'h100, 1'b0, 3'b111);
    put_entry(4, 16'h4000, 12'h010, 1'b1, 3'b001);
    put_entry(5, 16'h5000, 12'h020, 1'b1, 3'b001);
    put_len(5);
  endtask

  task automatic t_success();
    xlate("R7 read top of segment", 0, 'h0FF, 0, 3'd0, 16'h10FF);
    xlate("R7 write at offset 0", 0, 0, 1, 3'd0, 16'h1000);
    xlate("R7 execute", 1, 'h03F, 2, 3'd0, 16'h203F);
    xlate("R7 sum wraps", 2, 'h100, 0, 3'd0, 16'h0080);
  endtask

  task automatic t_latency();
    xlate("R2 response one cycle later", 0, 4, 0, 3'd0, 16'h1004);
    @(negedge clk);
    check("R2 idle cycle", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 3'd0, '0);
  endtask

  task automatic t_faults();
    xlate("R3 seg equal to count", 5, 0, 0, 3'd1, '0);
    xlate("R3 seg far above count", 7, 0, 0, 3'd1, '0);
    xlate("R4 invalid descriptor", 3, 0, 0, 3'd2, '0);
    xlate("R5 execute not allowed", 0, 0, 2, 3'd3, '0);
    xlate("R5 read not allowed", 1, 0, 0, 3'd3, '0);
    xlate("R5 reserved access", 4, 0, 3, 3'd3, '0);
    xlate("R6 offset equal to limit", 0, 'h100, 0, 3'd4, '0);
    xlate("R8 limit fault zero address", 4, 'hFFF, 0, 3'd4, '0);
  endtask

  task automatic t_priority();
    xlate("R10 range beats invalid", 6, 'hFFF, 3, 3'd1, '0);
    xlate("R10 invalid beats perm and limit", 3, 'hFFF, 3, 3'd2, '0);
    xlate("R10 perm beats limit", 4, 'h020, 1, 3'd3, '0);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 3'd0;
    cfg_base = 16'h7000; cfg_limit = 12'h100; cfg_valid = 1'b1; cfg_perm = 3'b011;
    req_valid = 1'b1; req_seg = 3'd0; req_off = 12'h010; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R9 same-cycle write not seen", rsp_valid, rsp_fault, rsp_paddr, 1'b1, 3'd0, 16'h1010);
    xlate("R9 new base seen next", 0, 'h010, 0, 3'd0, 16'h7010);
    put_len(6);
    xlate("R9 count raised", 5, 'h010, 0, 3'd0, 16'h5010);
  endtask

  initial begin
    t_reset();
    t_setup();
    t_success();
    t_latency();
    t_faults();
    t_priority();
    t_write_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule